// File: doc/BRIEF.md
# Capacitor Bank Relay Selector

This block turns a reactive-current measurement into a relay setting for a bank of ten identical 10 µF capacitors. It takes the RMS load current in milliamperes and the sine of the voltage-to-current phase angle. From these it forms the reactive current and converts it to a compensating capacitance. The conversion uses a line slope of 62200 V/s, which is a 311 V peak reached in a quarter period of 5 ms. The capacitance is given in whole microfarads and kept within what the bank can offer, 1 µF to 100 µF.

The microfarad value is then split into decimal digits. The tens digit is the number of capacitors placed in parallel. The series count is the reciprocal of one tenth of the units digit, rounded up. A relay enable mask switches in one capacitor per unit used, starting from capacitor 0. The datapath is sequential: a shift-add multiplier, a restoring divider for the slope and a second restoring divider for the digit split, so one request takes a few tens of cycles.

Requests enter on a valid/ready port. `in_ready` is high only while the block is idle, and a request is taken on a clock edge where both `in_valid` and `in_ready` are high. An upstream source that holds `in_valid` while `in_ready` is low is simply not served until the block is idle again. Results leave on `out_valid` as a one-cycle pulse with no back-pressure. The result fields stay registered until the next result.

Top module: `cap_bank_selector`

## Requirements
- R1: `in_ready` is high exactly when the block is idle. A request is accepted only on an edge with `in_valid` and `in_ready` both high. `in_valid` while `in_ready` is low has no effect, and the result that follows belongs to the accepted request.
- R2: The reactive current in mA is floor(`irms_ma` × `sin_q` / 32768). `sin_q` is unsigned fixed point with 15 fraction bits, so 32768 stands for 1.0.
- R3: The unclamped capacitance in µF is floor(reactive_mA × 10 / 622).
- R4: `cap_uf` is the unclamped capacitance limited to the range 1 to 100: a value of 0 gives 1, and anything above 100 gives 100.
- R5: `par_cnt` equals the tens digit of `cap_uf`, so 100 gives 10.
- R6: `ser_cnt` is ceil(10 / u), where u is the units digit of `cap_uf`. A units digit of 0 gives 0.
- R7: Bit i of `relay_en` (bit 0 is capacitor 0) is set exactly when i < min(`par_cnt` + `ser_cnt`, 10).
- R8: Each accepted request yields one `out_valid` pulse of exactly one cycle. The result fields keep their values until the next pulse.
- R9: While reset is applied, `in_ready` is 1, `out_valid` is 0 and all result fields are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block idle, request can be taken |
| irms_ma | input | 16 | RMS load current, mA |
| sin_q | input | 16 | Sine of phase angle, 15 fraction bits |
| out_valid | output | 1 | One-cycle result pulse |
| cap_uf | output | 7 | Required capacitance, µF, 1..100 |
| par_cnt | output | 5 | Capacitors in parallel |
| ser_cnt | output | 5 | Capacitors in series |
| relay_en | output | 10 | Relay enables, capacitor 0 in bit 0 |

## Verification
A wrong internal state shows up at the ports with the next result pulse. A multiplier or slope-divider fault gives a wrong `cap_uf`, often one that sits on a clamp limit when it should not. A digit-divider fault breaks the tie between `cap_uf`, `par_cnt` and `ser_cnt`. A mask fault gives a `relay_en` that is not a run of ones from bit 0 of the right length. A control-state fault shows within a cycle or two: `in_ready` rises while a request is still in flight, or `out_valid` stays high, fires twice or never fires. The scoreboard catches a missing or extra pulse as a count mismatch.

// File: rtl/cbs_pkg.sv
package cbs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MUL,
    ST_QUO,
    ST_DIG,
    ST_OUT
  } cbs_state_e;
endpackage

// File: rtl/cbs_mul.sv
// Sequential shift-add multiplier, one multiplier bit per cycle, LSB first.
module cbs_mul #(
  parameter int A_W = 16,
  parameter int B_W = 16,
  localparam int P_W = A_W + B_W,
  localparam int CNT_W = $clog2(B_W + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [A_W-1:0] a,
  input  logic [B_W-1:0] b,
  output logic [P_W-1:0] prod,
  output logic           done
);
  logic [P_W-1:0]   mcand;
  logic [B_W-1:0]   mplier;
  logic [P_W-1:0]   acc;
  logic [CNT_W-1:0] cnt;
  logic             busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcand  <= '0;
      mplier <= '0;
      acc    <= '0;
      cnt    <= '0;
      busy   <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        mcand  <= P_W'(a);
        mplier <= b;
        acc    <= '0;
        cnt    <= CNT_W'(B_W);
        busy   <= 1'b1;
      end else if (busy) begin
        if (mplier[0]) acc <= acc + mcand;
        mcand  <= mcand << 1;
        mplier <= mplier >> 1;
        cnt    <= cnt - CNT_W'(1);
        if (cnt == CNT_W'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign prod = acc;
endmodule

// File: rtl/cbs_div.sv
// Restoring divider, one quotient bit per cycle, MSB first.
module cbs_div #(
  parameter int N_W = 21,
  parameter int D_W = 10,
  localparam int CNT_W = $clog2(N_W + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [N_W-1:0] dividend,
  input  logic [D_W-1:0] divisor,
  output logic [N_W-1:0] quot,
  output logic [D_W-1:0] rem,
  output logic           done
);
  logic [N_W-1:0]   q;
  logic [D_W-1:0]   r;
  logic [CNT_W-1:0] cnt;
  logic             busy;
  logic [D_W:0]     trial;
  logic [D_W:0]     diff;
  logic             fits;

  assign trial = {r, q[N_W-1]};
  assign fits  = trial >= {1'b0, divisor};
  assign diff  = trial - {1'b0, divisor};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q    <= '0;
      r    <= '0;
      cnt  <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        q    <= dividend;
        r    <= '0;
        cnt  <= CNT_W'(N_W);
        busy <= 1'b1;
      end else if (busy) begin
        r   <= fits ? diff[D_W-1:0] : trial[D_W-1:0];
        q   <= {q[N_W-2:0], fits};
        cnt <= cnt - CNT_W'(1);
        if (cnt == CNT_W'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign quot = q;
  assign rem  = r;
endmodule

// File: rtl/cap_bank_selector.sv
module cap_bank_selector #(
  parameter int IRMS_W     = 16,
  parameter int SIN_W      = 16,
  parameter int SIN_FRAC   = 15,
  parameter int BANK_N     = 10,
  parameter int UNIT_UF    = 10,
  parameter int SLOPE_MUL  = 10,
  parameter int SLOPE_DIV  = 622,
  parameter int DIGIT_BASE = 10,
  localparam int CAP_MAX   = BANK_N * UNIT_UF,
  localparam int CAP_W     = $clog2(CAP_MAX + 1),
  localparam int CNT_W     = $clog2(BANK_N + DIGIT_BASE + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [IRMS_W-1:0] irms_ma,
  input  logic [SIN_W-1:0]  sin_q,
  output logic              out_valid,
  output logic [CAP_W-1:0]  cap_uf,
  output logic [CNT_W-1:0]  par_cnt,
  output logic [CNT_W-1:0]  ser_cnt,
  output logic [BANK_N-1:0] relay_en
);
  import cbs_pkg::*;

  localparam int PROD_W   = IRMS_W + SIN_W;
  localparam int REACT_W  = PROD_W - SIN_FRAC;
  localparam int SCALED_W = REACT_W + $clog2(SLOPE_MUL + 1);
  localparam int SLOPE_W  = $clog2(SLOPE_DIV + 1);
  localparam int DIG_W    = $clog2(DIGIT_BASE + 1);
  localparam int LUT_N    = 2 ** DIG_W;

  cbs_state_e state;
  logic       accept;

  // multiply stage
  logic [PROD_W-1:0]   prod;
  logic                mul_done;
  logic [REACT_W-1:0]  react_ma;
  logic [SCALED_W-1:0] scaled;

  // slope-divide stage
  logic                quo_start;
  logic [SCALED_W-1:0] quo_q;
  logic [SLOPE_W-1:0]  quo_r;
  logic                quo_done;
  logic [CAP_W-1:0]    cap_clamped;
  logic [CAP_W-1:0]    cap_r;

  // digit stage
  logic                dig_start;
  logic [CAP_W-1:0]    dig_q;
  logic [DIG_W-1:0]    dig_r;
  logic                dig_done;
  logic [CNT_W-1:0]    par_nxt;
  logic [CNT_W-1:0]    ser_nxt;
  logic [CNT_W-1:0]    used_sum;
  logic [CNT_W-1:0]    used;
  logic [BANK_N-1:0]   mask_nxt;
  logic [CNT_W-1:0]    ser_lut [LUT_N];

  assign in_ready = (state == ST_IDLE);
  assign accept   = in_valid && in_ready;

  cbs_mul #(.A_W(IRMS_W), .B_W(SIN_W)) u_mul (
    .clk   (clk),
    .rst_n (rst_n),
    .start (accept),
    .a     (irms_ma),
    .b     (sin_q),
    .prod  (prod),
    .done  (mul_done)
  );

  assign react_ma  = prod[PROD_W-1:SIN_FRAC];
  assign scaled    = SCALED_W'(react_ma) * SCALED_W'(SLOPE_MUL);
  assign quo_start = (state == ST_MUL) && mul_done;

  cbs_div #(.N_W(SCALED_W), .D_W(SLOPE_W)) u_quo (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (quo_start),
    .dividend (scaled),
    .divisor  (SLOPE_W'(SLOPE_DIV)),
    .quot     (quo_q),
    .rem      (quo_r),
    .done     (quo_done)
  );

  always_comb begin
    if (quo_q == '0)                           cap_clamped = CAP_W'(1);
    else if (quo_q > SCALED_W'(CAP_MAX))       cap_clamped = CAP_W'(CAP_MAX);
    else                                       cap_clamped = quo_q[CAP_W-1:0];
  end

  assign dig_start = (state == ST_QUO) && quo_done;

  cbs_div #(.N_W(CAP_W), .D_W(DIG_W)) u_dig (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (dig_start),
    .dividend (cap_clamped),
    .divisor  (DIG_W'(DIGIT_BASE)),
    .quot     (dig_q),
    .rem      (dig_r),
    .done     (dig_done)
  );

  // Series count per units digit: ceil(base / u), zero for u == 0.
  for (genvar u = 0; u < LUT_N; u++) begin : g_ser
    if (u == 0 || u >= DIGIT_BASE) begin : g_zero
      assign ser_lut[u] = '0;
    end else begin : g_val
      assign ser_lut[u] = CNT_W'((DIGIT_BASE + u - 1) / u);
    end
  end

  assign par_nxt  = dig_q[CNT_W-1:0];
  assign ser_nxt  = ser_lut[dig_r];
  assign used_sum = par_nxt + ser_nxt;
  assign used     = (used_sum > CNT_W'(BANK_N)) ? CNT_W'(BANK_N) : used_sum;

  for (genvar i = 0; i < BANK_N; i++) begin : g_mask
    assign mask_nxt[i] = used > CNT_W'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cap_r     <= '0;
      out_valid <= 1'b0;
      cap_uf    <= '0;
      par_cnt   <= '0;
      ser_cnt   <= '0;
      relay_en  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (accept) state <= ST_MUL;
        ST_MUL:  if (mul_done) state <= ST_QUO;
        ST_QUO: begin
          if (quo_done) begin
            cap_r <= cap_clamped;
            state <= ST_DIG;
          end
        end
        ST_DIG: begin
          if (dig_done) begin
            cap_uf    <= cap_r;
            par_cnt   <= par_nxt;
            ser_cnt   <= ser_nxt;
            relay_en  <= mask_nxt;
            out_valid <= 1'b1;
            state     <= ST_OUT;
          end
        end
        ST_OUT: begin
          out_valid <= 1'b0;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cbs_checker.sv
module cbs_checker #(
  parameter int CAP_W  = 7,
  parameter int CNT_W  = 5,
  parameter int BANK_N = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic [CAP_W-1:0]  cap_uf,
  input logic [CNT_W-1:0]  par_cnt,
  input logic [CNT_W-1:0]  ser_cnt,
  input logic [BANK_N-1:0] relay_en
);
  logic [31:0] units;
  logic [31:0] used;
  assign units = 32'(cap_uf) % 32'd10;
  assign used  = (32'(par_cnt) + 32'(ser_cnt) > 32'(BANK_N)) ? 32'(BANK_N)
                                                             : 32'(par_cnt) + 32'(ser_cnt);

  assert_busy_after_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  assert_cap_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (cap_uf >= CAP_W'(1) && cap_uf <= CAP_W'(100)));

  assert_par_tens_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (32'(par_cnt) == 32'(cap_uf) / 32'd10));

  assert_ser_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && units == 32'd0) |-> (ser_cnt == '0));

  assert_ser_ceil_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && units != 32'd0) |->
      (32'(ser_cnt) * units >= 32'd10 && (32'(ser_cnt) - 32'd1) * units < 32'd10));

  assert_mask_shape_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (((relay_en & (relay_en + BANK_N'(1))) == '0) &&
                   (32'($countones(relay_en)) == used)));

  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(cap_uf) && $stable(relay_en)));
endmodule

bind cap_bank_selector cbs_checker #(.CAP_W(CAP_W), .CNT_W(CNT_W), .BANK_N(BANK_N)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .cap_uf    (cap_uf),
  .par_cnt   (par_cnt),
  .ser_cnt   (ser_cnt),
  .relay_en  (relay_en)
);

// File: tb/cap_bank_selector_test.sv
`timescale 1ns/1ps
module cap_bank_selector_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] irms_ma = '0;
  logic [15:0] sin_q = '0;
  logic        out_valid;
  logic [6:0]  cap_uf;
  logic [4:0]  par_cnt;
  logic [4:0]  ser_cnt;
  logic [9:0]  relay_en;

  always #2 clk = ~clk;

  cap_bank_selector uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .irms_ma(irms_ma), .sin_q(sin_q), .out_valid(out_valid), .cap_uf(cap_uf),
    .par_cnt(par_cnt), .ser_cnt(ser_cnt), .relay_en(relay_en)
  );

  typedef struct {
    int cap;
    int par;
    int ser;
    int mask;
  } exp_t;

  exp_t exp_q[$];
  int   n_checks = 0;
  int   n_fails  = 0;
  bit   finished = 0;

  task automatic check(input string req, input int act, input int expv);
    n_checks++;
    if (act != expv) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Reference from the requirements (R2..R7).
  function automatic exp_t model(input int irms, input int sn);
    exp_t   e;
    longint react, c;
    int     u, used;
    react = (longint'(irms) * longint'(sn)) >> 15;   // R2
    c     = (react * 10) / 622;                       // R3
    if (c < 1) c = 1;                                 // R4
    if (c > 100) c = 100;
    e.cap = int'(c);
    e.par = e.cap / 10;                               // R5
    u     = e.cap % 10;
    e.ser = (u == 0) ? 0 : (10 + u - 1) / u;          // R6
    used  = (e.par + e.ser > 10) ? 10 : e.par + e.ser;
    e.mask = (1 << used) - 1;                         // R7
    return e;
  endfunction

  task automatic send(input int irms, input int sn);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    irms_ma  = 16'(irms);
    sin_q    = 16'(sn);
    exp_q.push_back(model(irms, sn));
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // R1: offer other requests while busy; they must be ignored.
  task automatic send_with_noise(input int irms, input int sn);
    send(irms, sn);
    for (int k = 0; k < 6; k++) begin
      in_valid = 1'b1;
      irms_ma  = 16'(9999 + k);
      sin_q    = 16'd30000;
      check("R1 in_ready low while busy", int'(in_ready), 0);
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  // Monitor / scoreboard
  bit  hold_pending = 0;
  bit  prev_valid   = 0;
  int  last_cap, last_par, last_ser, last_mask;

  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        check("R8 single-cycle pulse", int'(prev_valid), 0);
        if (exp_q.size() == 0) begin
          check("R1/R8 unexpected result", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check("R4 cap_uf", int'(cap_uf), e.cap);
          check("R5 par_cnt", int'(par_cnt), e.par);
          check("R6 ser_cnt", int'(ser_cnt), e.ser);
          check("R7 relay_en", int'(relay_en), e.mask);
        end
        last_cap  = int'(cap_uf);
        last_par  = int'(par_cnt);
        last_ser  = int'(ser_cnt);
        last_mask = int'(relay_en);
        hold_pending = 1;
      end else if (hold_pending) begin
        check("R8 cap_uf held", int'(cap_uf), last_cap);
        check("R8 relay_en held", int'(relay_en), last_mask);
        hold_pending = 0;
      end
      prev_valid = out_valid;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 in_ready in reset", int'(in_ready), 1);
    check("R9 out_valid in reset", int'(out_valid), 0);
    check("R9 cap_uf in reset", int'(cap_uf), 0);
    check("R9 relay_en in reset", int'(relay_en), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 in_ready idle", int'(in_ready), 1);

    send(1555, 32768);        // 25 uF: 2 par, 2 ser (R3, R5, R6)
    send(10, 32768);          // clamp low -> 1 uF (R4)
    send(20000, 32768);       // clamp high -> 100 uF, 10 par (R4, R5)
    send(3000, 0);            // zero sine -> 1 uF (R2, R4)
    send(6220, 32768);        // exactly 100 uF
    send(4000, 16384);        // half sine: 32 uF (R2)
    send(1200, 23170);        // ~0.707: 13 uF (R2, R6 ceil)
    send(1182, 32768);        // 19 uF: mask 3 bits (R7)
    send(6034, 32768);        // 97 uF: mask saturates at 10 (R7)
    send(685, 32768);         // 11 uF: 1 + 10 -> full mask (R7)
    send(65535, 65535);       // sine above 1.0 clamps (R4)
    send(2488, 32768);        // 40 uF: units 0 -> ser 0 (R6)
    send_with_noise(2177, 32768);  // 35 uF, busy requests ignored (R1)
    send(933, 32768);         // 15 uF back to back (R8)

    while (exp_q.size() != 0) @(negedge clk);
    repeat (5) @(negedge clk);
    check("R1/R8 all results seen", exp_q.size(), 0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end
endmodule